// File: doc/BRIEF.md
# Digital PWM Controller with Fault Latch

This block produces one active-high gate drive bit for a fixed-frequency switching power stage. A free-running period counter acts as both the oscillator and the ramp. Each period opens with an on window and closes with an enforced off window, so the counter fixes both the longest possible high time and the shortest possible low time. Inside the on window, a turn-off latch is armed at count zero. The pulse ends when the ramp (a fixed minimum plus the count) reaches the smaller of the duty command and a soft-start level, or when any stop trip arrives. Whenever a reset source is active, it overrides the arming of that latch.

A second latch, the fault latch, removes the drive in the same cycle that any fault appears. The faults are overvoltage, undervoltage, reference overcurrent, or a supply word that is not qualified by the supply hysteresis. While a fault is present, the soft-start level is held at zero. Once the faults clear, the level climbs one step per period up to a ceiling. The fault latch re-arms only while the level is below a low threshold. That threshold lies below the ramp minimum, so the duty cycle grows from zero. If overcurrent trips occur in two periods in a row, the block skips the next arming so that one pulse is dropped.

All trips reach the block as synchronous flags. The block is placed between digital comparators and a gate driver.

Top module: `pwm_fault_ctl`

## Requirements
- R1: While rst_n is low, gate_out is 0. Reset clears the counter, the soft-start level and both latches.
- R2: gate_out can be high only after vs_level has reached at least 200. Once qualified, the supply stays qualified down to 160. Below 160, gate_out is 0 until vs_level is back at 200 or more.
- R3: A period is 64 cycles. The turn-off latch is armed at count 0, so a pulse is high starting in the cycle with count 1.
- R4: With no trips, the pulse is high for min(duty_cmd, soft-start level) − 8 cycles. The result is floored at 0 and capped by R5.
- R5: gate_out is 0 in every cycle with count 48 or above.
- R6: A cm_trip, oc_trip or aux_oc_trip in the cycle with count k (k ≥ 1) ends the pulse. The last high cycle is k.
- R7: If any stop source (a trip, or ramp ≥ limit) is active in the cycle with count 0, there is no pulse in that period.
- R8: ov_flag, uv_flag or ref_oc_flag, or an unqualified supply, forces gate_out to 0 in the same cycle.
- R9: A fault sets the soft-start level to 0 on the next edge. After that, with no fault present, the level rises by 4 at every period end. The fault latch re-arms only while the level is below 6.
- R10: gate_out stays 0 until the soft-start level exceeds the ramp minimum of 8.
- R11: The soft-start level never exceeds 48. With a large duty command, the pulse therefore lasts 40 cycles.
- R12: If oc_trip occurs in two consecutive periods, the period that follows has no pulse. A single period with oc_trip does not cause a skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_cmd | input | 8 | Duty command, compared against the ramp |
| cm_trip | input | 1 | Current-mode peak trip; ends the pulse |
| oc_trip | input | 1 | Overcurrent trip; ends the pulse and feeds skip history |
| aux_oc_trip | input | 1 | Auxiliary overcurrent trip; ends the pulse |
| ov_flag | input | 1 | Overvoltage fault |
| uv_flag | input | 1 | Undervoltage fault |
| ref_oc_flag | input | 1 | Reference overcurrent fault |
| vs_level | input | 8 | Supply measurement word for the hysteresis check |
| gate_out | output | 1 | Active-high gate drive |

## Verification
The main function is exercised with duty commands below the ramp minimum, in mid range, and above the soft-start ceiling. Together these separate the floor of the ramp, the normal linear width and the clamp. Single-cycle stop trips are placed mid-pulse and at count zero, which separates truncation of a pulse from a blocked set. Overcurrent is applied in isolated periods and in back-to-back periods to show that only repetition skips a pulse. The supply word is stepped across both thresholds in both directions, and one-cycle faults are followed by a watched soft-start recovery. A behavioural model is compared against the output in every cycle.

// File: rtl/pwm_ctl_pkg.sv
package pwm_ctl_pkg;

  typedef struct packed {
    logic cm;
    logic oc;
    logic aux;
  } stop_req_t;

  function automatic int unsigned lesser(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction

  function automatic int unsigned ramp_at(input int unsigned base, input int unsigned count);
    return base + count;
  endfunction

  function automatic int unsigned ss_advance(input int unsigned lvl, input int unsigned step,
                                             input int unsigned ceil);
    int unsigned nxt;
    nxt = lvl + step;
    return (nxt > ceil) ? ceil : nxt;
  endfunction

  function automatic logic hyst_next(input logic state, input int unsigned lvl,
                                     input int unsigned on_th, input int unsigned off_th);
    if (lvl >= on_th) return 1'b1;
    if (lvl < off_th) return 1'b0;
    return state;
  endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int PERIOD = 64,
  parameter int ON_MAX = 48,
  parameter int CW     = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cnt,
  output logic          period_start,
  output logic          period_end,
  output logic          on_window
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt          = cnt_q;
  assign period_start = (cnt_q == '0);
  assign period_end   = (cnt_q == LAST);
  assign on_window    = (32'(cnt_q) < ON_MAX);
endmodule

// File: rtl/pwm_supply_mon.sv
module pwm_supply_mon
  import pwm_ctl_pkg::*;
#(
  parameter int VW     = 8,
  parameter int VS_ON  = 200,
  parameter int VS_OFF = 160
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] vs_level,
  output logic          supply_ok
);
  logic sup_q;
  logic sup_d;

  assign sup_d = hyst_next(sup_q, 32'(vs_level), VS_ON, VS_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sup_q <= 1'b0;
    else        sup_q <= sup_d;
  end

  assign supply_ok = sup_d;
endmodule

// File: rtl/pwm_softstart.sv
module pwm_softstart
  import pwm_ctl_pkg::*;
#(
  parameter int DW      = 8,
  parameter int SS_STEP = 4,
  parameter int SS_MAX  = 48,
  parameter int SS_LOW  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fault_now,
  input  logic          period_end,
  output logic [DW-1:0] ss_lvl,
  output logic          ss_low
);
  logic [DW-1:0] ss_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ss_q <= '0;
    else if (fault_now)  ss_q <= '0;
    else if (period_end) ss_q <= DW'(ss_advance(32'(ss_q), SS_STEP, SS_MAX));
  end

  assign ss_lvl = ss_q;
  assign ss_low = (32'(ss_q) < SS_LOW);
endmodule

// File: rtl/pwm_latches.sv
module pwm_latches
  import pwm_ctl_pkg::*;
#(
  parameter bit SKIP_EN = 1'b1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      period_start,
  input  logic      period_end,
  input  logic      on_window,
  input  logic      duty_end,
  input  stop_req_t stop_req,
  input  logic      fault_now,
  input  logic      ss_low,
  output logic      pulse_en,
  output logic      fault_ok,
  output logic      skip_q
);
  logic any_stop;
  logic set_ok;
  logic pulse_q;
  logic fault_q;

  assign any_stop = duty_end | stop_req.cm | stop_req.oc | stop_req.aux;
  assign set_ok   = period_start & ~skip_q;

  // turn-off latch: reset dominates set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pulse_q <= 1'b0;
    else if (any_stop)   pulse_q <= 1'b0;
    else if (set_ok)     pulse_q <= 1'b1;
    else if (!on_window) pulse_q <= 1'b0;
  end

  // fault latch: any fault dominates re-arm
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fault_q <= 1'b0;
    else if (fault_now) fault_q <= 1'b0;
    else if (ss_low)    fault_q <= 1'b1;
  end

  generate
    if (SKIP_EN) begin : g_skip
      logic oc_seen;
      logic oc_prev;
      logic skip_r;
      logic oc_hit;

      assign oc_hit = oc_seen | stop_req.oc;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          oc_seen <= 1'b0;
          oc_prev <= 1'b0;
          skip_r  <= 1'b0;
        end else if (period_end) begin
          skip_r  <= oc_hit & oc_prev;
          oc_prev <= oc_hit;
          oc_seen <= 1'b0;
        end else begin
          oc_seen <= oc_hit;
        end
      end

      assign skip_q = skip_r;
    end else begin : g_noskip
      assign skip_q = 1'b0;
    end
  endgenerate

  assign pulse_en = pulse_q;
  assign fault_ok = fault_q;
endmodule

// File: rtl/pwm_fault_ctl.sv
module pwm_fault_ctl
  import pwm_ctl_pkg::*;
#(
  parameter int DW       = 8,
  parameter int VW       = 8,
  parameter int PERIOD   = 64,
  parameter int ON_MAX   = 48,
  parameter int RAMP_MIN = 8,
  parameter int SS_STEP  = 4,
  parameter int SS_MAX   = 48,
  parameter int SS_LOW   = 6,
  parameter int VS_ON    = 200,
  parameter int VS_OFF   = 160,
  parameter bit SKIP_EN  = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] duty_cmd,
  input  logic          cm_trip,
  input  logic          oc_trip,
  input  logic          aux_oc_trip,
  input  logic          ov_flag,
  input  logic          uv_flag,
  input  logic          ref_oc_flag,
  input  logic [VW-1:0] vs_level,
  output logic          gate_out
);
  localparam int CW = $clog2(PERIOD);

  logic [CW-1:0] cnt;
  logic          period_start;
  logic          period_end;
  logic          on_window;
  logic          supply_ok;
  logic [DW-1:0] ss_lvl;
  logic          ss_low;
  logic          pulse_en;
  logic          fault_ok;
  logic          skip_q;
  logic          fault_now;
  logic          duty_end;
  int unsigned   ramp_now;
  int unsigned   limit_now;
  stop_req_t     stops;

  pwm_timebase #(.PERIOD(PERIOD), .ON_MAX(ON_MAX), .CW(CW)) u_tb (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .period_start(period_start),
    .period_end(period_end), .on_window(on_window)
  );

  pwm_supply_mon #(.VW(VW), .VS_ON(VS_ON), .VS_OFF(VS_OFF)) u_sup (
    .clk(clk), .rst_n(rst_n), .vs_level(vs_level), .supply_ok(supply_ok)
  );

  assign fault_now = ov_flag | uv_flag | ref_oc_flag | ~supply_ok;

  pwm_softstart #(.DW(DW), .SS_STEP(SS_STEP), .SS_MAX(SS_MAX), .SS_LOW(SS_LOW)) u_ss (
    .clk(clk), .rst_n(rst_n), .fault_now(fault_now), .period_end(period_end),
    .ss_lvl(ss_lvl), .ss_low(ss_low)
  );

  assign ramp_now  = ramp_at(RAMP_MIN, 32'(cnt));
  assign limit_now = lesser(32'(duty_cmd), 32'(ss_lvl));
  assign duty_end  = (ramp_now >= limit_now);

  assign stops.cm  = cm_trip;
  assign stops.oc  = oc_trip;
  assign stops.aux = aux_oc_trip;

  pwm_latches #(.SKIP_EN(SKIP_EN)) u_lat (
    .clk(clk), .rst_n(rst_n), .period_start(period_start), .period_end(period_end),
    .on_window(on_window), .duty_end(duty_end), .stop_req(stops),
    .fault_now(fault_now), .ss_low(ss_low), .pulse_en(pulse_en),
    .fault_ok(fault_ok), .skip_q(skip_q)
  );

  assign gate_out = pulse_en & on_window & fault_ok & ~fault_now;
endmodule

// File: rtl/pwm_fault_ctl_chk.sv
module pwm_fault_ctl_chk #(
  parameter int DW       = 8,
  parameter int VW       = 8,
  parameter int CW       = 6,
  parameter int ON_MAX   = 48,
  parameter int RAMP_MIN = 8,
  parameter int SS_MAX   = 48,
  parameter int VS_OFF   = 160
) (
  input logic          clk,
  input logic          rst_n,
  input logic          gate_out,
  input logic [CW-1:0] cnt,
  input logic [DW-1:0] ss_lvl,
  input logic          fault_now,
  input logic          skip_q,
  input logic [VW-1:0] vs_level
);
  // R2
  supply_low_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(vs_level) < VS_OFF) |-> !gate_out);

  // R3
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_out) |-> (cnt == CW'(1)));

  // R5
  off_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cnt) >= ON_MAX) |-> !gate_out);

  // R8
  fault_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_now |-> !gate_out);

  // R9
  ss_discharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_now |=> (ss_lvl == '0));

  // R10
  ss_above_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_out |-> (32'(ss_lvl) > RAMP_MIN));

  // R11
  ss_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ss_lvl) <= SS_MAX);

  // R12
  skip_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_q && cnt == '0) |=> !gate_out);
endmodule

bind pwm_fault_ctl pwm_fault_ctl_chk #(
  .DW(DW), .VW(VW), .CW(CW), .ON_MAX(ON_MAX), .RAMP_MIN(RAMP_MIN),
  .SS_MAX(SS_MAX), .VS_OFF(VS_OFF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .gate_out(gate_out), .cnt(cnt), .ss_lvl(ss_lvl),
  .fault_now(fault_now), .skip_q(skip_q), .vs_level(vs_level)
);

// File: tb/pwm_fault_ctl_bench.sv
`timescale 1ns/1ps
module pwm_fault_ctl_bench;
  localparam int PER = 64, ONM = 48, RMIN = 8, STEP = 4, SSMAX = 48, SSLOW = 6;
  localparam int VON = 200, VOFF = 160;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] duty_cmd = 8'd30;
  logic       cm_trip = 1'b0, oc_trip = 1'b0, aux_oc_trip = 1'b0;
  logic       ov_flag = 1'b0, uv_flag = 1'b0, ref_oc_flag = 1'b0;
  logic [7:0] vs_level = 8'd0;
  logic       gate_out;

  pwm_fault_ctl u_pwm_fault_ctl (
    .clk(clk), .rst_n(rst_n), .duty_cmd(duty_cmd), .cm_trip(cm_trip), .oc_trip(oc_trip),
    .aux_oc_trip(aux_oc_trip), .ov_flag(ov_flag), .uv_flag(uv_flag),
    .ref_oc_flag(ref_oc_flag), .vs_level(vs_level), .gate_out(gate_out)
  );

  always #5 clk = ~clk;

  int    errs = 0, checks = 0, cyc = 0;
  string cur_req = "R1";
  int    first_hi, late_hi;

  // behavioural reference state
  int m_cnt = 0, m_ss = 0;
  bit m_pulse = 0, m_flt = 0, m_sup = 0, m_seen = 0, m_prev = 0, m_skip = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp,
                       input string what);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  function automatic bit sup_next();
    if (vs_level >= VON) return 1'b1;
    if (vs_level < VOFF) return 1'b0;
    return m_sup;
  endfunction

  function automatic bit fault_in();
    return ov_flag || uv_flag || ref_oc_flag || !sup_next();
  endfunction

  always @(posedge clk) begin : model
    int lim;
    bit stop, flt, hit;
    cyc++;
    if (!rst_n) begin
      m_cnt = 0; m_ss = 0; m_pulse = 0; m_flt = 0; m_sup = 0;
      m_seen = 0; m_prev = 0; m_skip = 0;
    end else begin
      lim  = (duty_cmd < m_ss) ? int'(duty_cmd) : m_ss;
      stop = (RMIN + m_cnt >= lim) || cm_trip || oc_trip || aux_oc_trip;
      flt  = fault_in();
      if (stop) m_pulse = 0;
      else if (m_cnt == 0 && !m_skip) m_pulse = 1;
      else if (m_cnt >= ONM) m_pulse = 0;
      if (flt) m_flt = 0;
      else if (m_ss < SSLOW) m_flt = 1;
      hit = m_seen || oc_trip;
      if (m_cnt == PER - 1) begin
        m_skip = hit && m_prev; m_prev = hit; m_seen = 0;
        if (!flt) m_ss = (m_ss + STEP > SSMAX) ? SSMAX : m_ss + STEP;
      end else m_seen = hit;
      if (flt) m_ss = 0;
      m_sup = sup_next();
      m_cnt = (m_cnt + 1) % PER;
    end
    #2;
    begin : cmp
      bit exp_g;
      exp_g = rst_n && m_pulse && (m_cnt < ONM) && m_flt && !fault_in();
      check(gate_out == exp_g, cur_req, gate_out, exp_g, "per-cycle gate");
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic run_period(input int sel, input int at, output int w, output bit g_at);
    while (m_cnt != 0) @(negedge clk);
    w = 0; g_at = 0; first_hi = -1; late_hi = 0;
    for (int c = 0; c < PER; c++) begin
      cm_trip     = (sel == 1 && c == at);
      oc_trip     = (sel == 2 && c == at);
      aux_oc_trip = (sel == 3 && c == at);
      ov_flag     = (sel == 4 && c == at);
      uv_flag     = (sel == 5 && c == at);
      ref_oc_flag = (sel == 6 && c == at);
      #1;
      if (gate_out) begin
        w++;
        if (first_hi < 0) first_hi = c;
        if (c >= ONM) late_hi++;
      end
      if (c == at) g_at = gate_out;
      @(negedge clk);
    end
    {cm_trip, oc_trip, aux_oc_trip, ov_flag, uv_flag, ref_oc_flag} = '0;
  endtask

  task automatic settle(input int n);
    int w; bit g;
    for (int i = 0; i < n; i++) run_period(0, 0, w, g);
  endtask

  initial begin
    int w, hi;
    bit g;
    repeat (5) @(negedge clk);
    #1 check(gate_out == 1'b0, "R1", gate_out, 0, "gate during reset");
    @(negedge clk);
    rst_n = 1'b1;

    cur_req = "R2"; vs_level = 8'd180; hi = 0;
    for (int i = 0; i < 200; i++) begin
      #1; if (gate_out) hi++;
      @(negedge clk);
    end
    check(hi == 0, "R2", hi, 0, "high cycles before supply qualified");

    vs_level = 8'd220; cur_req = "R10";
    run_period(0, 0, w, g); check(w == 0, "R10", w, 0, "width with soft-start below ramp floor");
    cur_req = "R9"; settle(14);

    cur_req = "R4"; duty_cmd = 8'd30;
    run_period(0, 0, w, g); check(w == 22, "R4", w, 22, "width duty 30");
    check(first_hi == 1, "R3", first_hi, 1, "first high count");
    duty_cmd = 8'd5;
    run_period(0, 0, w, g); check(w == 0, "R4", w, 0, "width duty below floor");
    cur_req = "R11"; duty_cmd = 8'd200;
    run_period(0, 0, w, g); check(w == 40, "R11", w, 40, "width clamped by ceiling");
    check(late_hi == 0, "R5", late_hi, 0, "high cycles at count>=48");
    duty_cmd = 8'd30;

    cur_req = "R2"; vs_level = 8'd180;
    run_period(0, 0, w, g); check(w == 22, "R2", w, 22, "width inside hysteresis band");

    cur_req = "R6";
    run_period(1, 10, w, g); check(w == 10, "R6", w, 10, "cm_trip at 10");
    run_period(3, 5, w, g);  check(w == 5, "R6", w, 5, "aux_oc_trip at 5");
    run_period(2, 10, w, g); check(w == 10, "R6", w, 10, "oc_trip at 10");
    cur_req = "R12";
    run_period(0, 0, w, g);  check(w == 22, "R12", w, 22, "no skip after single oc period");

    cur_req = "R7";
    run_period(2, 0, w, g);  check(w == 0, "R7", w, 0, "oc at count 0 blocks set");
    cur_req = "R12";
    run_period(2, 3, w, g);  check(w == 3, "R12", w, 3, "second oc period");
    run_period(0, 0, w, g);  check(w == 0, "R12", w, 0, "skipped period");
    run_period(0, 0, w, g);  check(w == 22, "R12", w, 22, "resume after skip");

    cur_req = "R8";
    run_period(4, 5, w, g);
    check(g == 1'b0, "R8", g, 0, "gate in ov cycle");
    check(w == 4, "R8", w, 4, "width cut by ov");
    cur_req = "R9";
    run_period(0, 0, w, g); check(w == 0, "R9", w, 0, "recovery period 1");
    run_period(0, 0, w, g); check(w == 0, "R9", w, 0, "recovery period 2");
    run_period(0, 0, w, g); check(w == 4, "R9", w, 4, "recovery period 3");
    run_period(0, 0, w, g); check(w == 8, "R9", w, 8, "recovery period 4");
    settle(10);

    cur_req = "R8";
    run_period(5, 8, w, g);
    check(g == 1'b0 && w == 7, "R8", w, 7, "uv at 8");
    cur_req = "R9"; settle(14);
    cur_req = "R8";
    run_period(6, 12, w, g);
    check(g == 1'b0 && w == 11, "R8", w, 11, "ref_oc at 12");
    cur_req = "R9"; settle(14);

    cur_req = "R2";
    vs_level = 8'd150; run_period(0, 0, w, g); check(w == 0, "R2", w, 0, "supply below off threshold");
    vs_level = 8'd180; run_period(0, 0, w, g); check(w == 0, "R2", w, 0, "band after drop stays off");
    vs_level = 8'd220; run_period(0, 0, w, g); check(w == 0, "R2", w, 0, "requalified, soft start from 0");
    cur_req = "R9"; settle(14);
    cur_req = "R4";
    run_period(0, 0, w, g); check(w == 22, "R4", w, 22, "width after full recovery");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule